// File: doc/BRIEF.md
# Interrupt Enable and Status Unit

This unit collects single-cycle event pulses from four sources: data available, status valid, locality change and command ready. Each pulse is held in a sticky status bit that software clears by writing a one to it. The unit masks the status bits with a per-source enable and a global enable, and it drives a single interrupt line. Software selects the line's signalling style: active-high level, active-low level, rising-edge pulse or falling-edge pulse.

A small register port gives software access to four registers:
- an enable/mode register;
- an 8-bit vector register, which only stores a value for software;
- the status register;
- a read-only capability register, which reports the supported sources, the four signalling styles and whether the burst count is static.

Reads are combinational on the current address. Writes take effect at the clock edge on which `reg_we` is sampled high.

Top module: `irq_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable register, the status register and the vector register all read zero, and `irq_out` is low.
- R2: A pulse on `src_pulse[i]` sets the status bit at the source's position: index 0 sets bit 0, index 1 sets bit 1, index 2 sets bit 2 and index 3 sets bit 7. The bit is set whatever the enables hold, and it stays set until it is cleared. Status offset is 0x10.
- R3: A write to the status register clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: When a source pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: While enable bit 31 (global enable; enable offset 0x08) is 0, `irq_out` stays at its idle level. The idle level is low in modes 00 and 10 and high in modes 01 and 11.
- R6: A set status bit whose per-source enable bit (the same bit position as in the status register) is 0 does not assert the line.
- R7: Enable bits 4:3 select the mode. In mode 00 (level, active high), `irq_out` is high exactly while the global enable is set and some enabled status bit is set.
- R8: In mode 01 (level, active low), `irq_out` is low while an interrupt is pending and high otherwise.
- R9: In mode 10 (rising edge), each 0-to-1 change of the pending condition gives a high pulse of exactly one cycle. Further source events while the condition is already pending give no new pulse.
- R10: In mode 11 (falling edge), the line idles high and each new pending condition gives a low pulse of exactly one cycle.
- R11: The capability register (offset 0x14) is read-only. Its bits are:
  - bits 0, 1, 2 and 7: sources supported;
  - bits 3, 4, 5 and 6: level-high, level-low, rising-edge and falling-edge signalling;
  - bit 8: equal to parameter STATIC_BURST.
  
  With the default parameters it reads 0x1FF, and writes to it have no effect.
- R12: The vector register (offset 0x0C) stores and returns 8 bits. The enable register reads back only bits 31, 7, 4, 3, 2, 1 and 0; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_pulse | input | 4 | Event pulses: 0 data available, 1 status valid, 2 locality change, 3 command ready |
| irq_out | output | 1 | Interrupt line |

## Verification
The assertions take for granted that each source pulse is a one-cycle event and that the register port holds `reg_addr` and `reg_wdata` steady while `reg_we` is high. The edge-pulse property also assumes that the mode does not change through a write in the cycle after a pulse; for that reason it is disabled whenever `reg_we` is high. The bench drives every input on the falling clock edge and pulses each strobe for exactly one cycle. It changes the mode only while the status register is empty, so every check sees a settled pending condition.

// File: rtl/irq_unit_pkg.sv
// Package: register offsets, source bit positions and line modes for the interrupt unit.
// Assumes: offsets fit in the top module's ADDR_W address.
package irq_unit_pkg;
    localparam int NUM_SRC    = 4;
    localparam int OFS_ENABLE = 'h08;
    localparam int OFS_VECTOR = 'h0C;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_CAPS   = 'h14;
    localparam int GLOBAL_BIT = 31;
    localparam int MODE_LSB   = 3;
    localparam int VEC_W      = 8;
    localparam int BURST_BIT  = 8;
    // Register bit of each source, in src_pulse index order
    localparam int SRC_POS [NUM_SRC] = '{0, 1, 2, 7};

    typedef enum logic [1:0] {
        MODE_LVL_HI    = 2'b00,
        MODE_LVL_LO    = 2'b01,
        MODE_EDGE_RISE = 2'b10,
        MODE_EDGE_FALL = 2'b11
    } line_mode_e;
endpackage

// File: rtl/irq_ctrl_regs.sv
// Holds the global enable, per-source enables, line mode and vector value.
// Assumes: wr_ctl and wr_vec are already decoded and never high together.
module irq_ctrl_regs
    import irq_unit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctl,
    input  logic               wr_vec,
    input  logic [31:0]        wdata,
    output logic               glob_en,
    output logic [NUM_SRC-1:0] src_en,
    output line_mode_e         mode,
    output logic [VEC_W-1:0]   vector
);
    // Control register: global enable, mode field, source enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            mode    <= MODE_LVL_HI;
            src_en  <= '0;
        end else if (wr_ctl) begin
            glob_en <= wdata[GLOBAL_BIT];
            mode    <= line_mode_e'(wdata[MODE_LSB +: 2]);
            for (int i = 0; i < NUM_SRC; i++) begin
                src_en[i] <= wdata[SRC_POS[i]];
            end
        end
    end

    // Vector register: plain storage for software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector <= '0;
        end else if (wr_vec) begin
            vector <= wdata[VEC_W-1:0];
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
// Sticky event bits, one per source; set by pulses, cleared by write-one.
// Assumes: clr[i] is already qualified with the status write strobe.
module irq_status_bank
    import irq_unit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] sts
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // One status bit; a set in the same cycle overrides a clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts[g] <= 1'b0;
            end else if (set[g]) begin
                sts[g] <= 1'b1;
            end else if (clr[g]) begin
                sts[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_line_drive.sv
// Forms the pending condition and shapes the line for level/edge and polarity.
// Assumes: inputs come from registers, so the output is glitch-free per cycle.
module irq_line_drive
    import irq_unit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sts,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glob_en,
    input  line_mode_e         mode,
    output logic               line
);
    logic pending;
    logic pend_d1;
    logic active;

    // Pending: global gate over any enabled status bit
    always_comb pending = glob_en & (|(sts & src_en));

    // Previous pending value, used to detect new assertions
    always_ff @(posedge clk) begin
        if (!rst_n) pend_d1 <= 1'b0;
        else        pend_d1 <= pending;
    end

    // Edge modes give a one-cycle pulse; polarity set by mode bit 0
    always_comb begin
        active = mode[1] ? (pending & ~pend_d1) : pending;
        line   = active ^ mode[0];
    end
endmodule

// File: rtl/irq_unit.sv
// Top: register decode and read mux around the control, status and line blocks.
// Assumes: reads are combinational; writes land on the edge where reg_we is high.
module irq_unit
    import irq_unit_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter bit STATIC_BURST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VECTOR);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFS_CAPS);

    logic               wr_ctl, wr_vec, wr_sts;
    logic [NUM_SRC-1:0] clr_v;
    logic               glob_en;
    logic [NUM_SRC-1:0] src_en;
    line_mode_e         mode_q;
    logic [VEC_W-1:0]   vector_q;
    logic [NUM_SRC-1:0] sts_q;
    logic [31:0]        caps;

    // Write decode and per-source clear vector
    always_comb begin
        wr_ctl = reg_we && (reg_addr == A_EN);
        wr_vec = reg_we && (reg_addr == A_VEC);
        wr_sts = reg_we && (reg_addr == A_STS);
        for (int i = 0; i < NUM_SRC; i++) begin
            clr_v[i] = wr_sts & reg_wdata[SRC_POS[i]];
        end
    end

    irq_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_ctl),
        .wr_vec  (wr_vec),
        .wdata   (reg_wdata),
        .glob_en (glob_en),
        .src_en  (src_en),
        .mode    (mode_q),
        .vector  (vector_q)
    );

    irq_status_bank u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (src_pulse),
        .clr   (clr_v),
        .sts   (sts_q)
    );

    irq_line_drive u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .sts     (sts_q),
        .src_en  (src_en),
        .glob_en (glob_en),
        .mode    (mode_q),
        .line    (irq_out)
    );

    // Capability word: sources, all four signalling styles, burst flag
    always_comb begin
        caps = '0;
        for (int i = 0; i < NUM_SRC; i++) caps[SRC_POS[i]] = 1'b1;
        caps[MODE_LSB +: 4] = 4'hF;
        caps[BURST_BIT]     = STATIC_BURST;
    end

    // Read mux: fields placed at their register positions
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_EN) begin
            reg_rdata[GLOBAL_BIT]     = glob_en;
            reg_rdata[MODE_LSB +: 2]  = mode_q;
            for (int i = 0; i < NUM_SRC; i++) reg_rdata[SRC_POS[i]] = src_en[i];
        end else if (reg_addr == A_VEC) begin
            reg_rdata[VEC_W-1:0] = vector_q;
        end else if (reg_addr == A_STS) begin
            for (int i = 0; i < NUM_SRC; i++) reg_rdata[SRC_POS[i]] = sts_q[i];
        end else if (reg_addr == A_CAP) begin
            reg_rdata = caps;
        end
    end
endmodule

// File: rtl/irq_unit_chk.sv
// Checker for irq_unit: relates port activity to status and line behaviour.
// Assumes: one-cycle source pulses; address and data stable under reg_we.
module irq_unit_chk
    import irq_unit_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_we,
    input logic [31:0]        reg_wdata,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] sts,
    input logic               glob_en,
    input logic [1:0]         mode
);
    logic sts_wr;
    assign sts_wr = reg_we && (reg_addr == ADDR_W'(OFS_STATUS));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            src_pulse[g] |=> sts[g]); // R2
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            sts[g] && !(sts_wr && reg_wdata[SRC_POS[g]]) |=> sts[g]); // R2
        AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            sts_wr && reg_wdata[SRC_POS[g]] && !src_pulse[g] |=> !sts[g]); // R3
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            sts_wr && reg_wdata[SRC_POS[g]] && src_pulse[g] |=> sts[g]); // R4
    end

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> irq_out == mode[0]); // R5
    AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) && (sts == '0) |-> !irq_out); // R7
    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) && irq_out && !reg_we |=> !irq_out); // R9
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) && !irq_out && !reg_we |=> irq_out); // R10
endmodule

bind irq_unit irq_unit_chk u_irq_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .src_pulse (src_pulse),
    .irq_out   (irq_out),
    .sts       (sts_q),
    .glob_en   (glob_en),
    .mode      (mode_q)
);

// File: tb/test_irq_unit.sv
// Directed bench for irq_unit: one task per scenario, each checking its results.
module test_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  src_pulse = '0;
    logic        irq_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_EN = 8'h08, A_VEC = 8'h0C, A_STS = 8'h10, A_CAP = 8'h14;

    always #4 clk = ~clk;

    irq_unit i_irq_unit (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_we (reg_we),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .src_pulse (src_pulse), .irq_out (irq_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr_pulse(logic [7:0] a, logic [31:0] d, logic [3:0] p);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1; src_pulse = p;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; src_pulse = '0;
    endtask

    task automatic pulse(logic [3:0] p);
        @(negedge clk);
        src_pulse = p;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 enable", A_EN, 32'h0);
        rd_chk("R1 status", A_STS, 32'h0);
        rd_chk("R1 vector", A_VEC, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        rd_chk("R11 caps", A_CAP, 32'h0000_01FF);
    endtask

    task automatic t_set_clear();
        pulse(4'b0001);
        rd_chk("R2 src0", A_STS, 32'h01);
        check("R5 no global", {31'b0, irq_out}, 32'h0);
        pulse(4'b1000);
        rd_chk("R2 src3 bit7", A_STS, 32'h81);
        pulse(4'b0110);
        rd_chk("R2 src1 src2", A_STS, 32'h87);
        wr(A_STS, 32'h05);
        rd_chk("R3 partial clear", A_STS, 32'h82);
        wr(A_STS, 32'h0);
        rd_chk("R3 zero write", A_STS, 32'h82);
        wr(A_STS, 32'h82);
        rd_chk("R3 full clear", A_STS, 32'h0);
        wr_pulse(A_STS, 32'h02, 4'b0010);
        rd_chk("R4 set wins", A_STS, 32'h02);
        wr(A_STS, 32'hFF);
        rd_chk("R4 cleared after", A_STS, 32'h0);
    endtask

    task automatic t_regs();
        wr(A_EN, 32'hFFFF_FFFF);
        rd_chk("R12 enable mask", A_EN, 32'h8000_009F);
        check("R10 idle high", {31'b0, irq_out}, 32'h1);
        wr(A_VEC, 32'h0000_12A5);
        rd_chk("R12 vector", A_VEC, 32'hA5);
        wr(A_CAP, 32'h0);
        rd_chk("R11 caps read-only", A_CAP, 32'h0000_01FF);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_gating();
        wr(A_EN, 32'h0000_0001);
        pulse(4'b0001);
        check("R5 global off", {31'b0, irq_out}, 32'h0);
        wr(A_EN, 32'h8000_0001);
        check("R7 level high asserted", {31'b0, irq_out}, 32'h1);
        wr(A_STS, 32'h01);
        check("R7 level high released", {31'b0, irq_out}, 32'h0);
        pulse(4'b0100);
        check("R6 source disabled", {31'b0, irq_out}, 32'h0);
        wr(A_STS, 32'h04);
    endtask

    task automatic t_level_low();
        wr(A_EN, 32'h8000_0089);
        check("R8 idle", {31'b0, irq_out}, 32'h1);
        pulse(4'b1000);
        check("R8 asserted low", {31'b0, irq_out}, 32'h0);
        wr(A_STS, 32'h80);
        check("R8 released", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_rise();
        wr(A_EN, 32'h8000_0011);
        check("R9 idle", {31'b0, irq_out}, 32'h0);
        pulse(4'b0001);
        check("R9 pulse", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R9 one cycle", {31'b0, irq_out}, 32'h0);
        pulse(4'b0001);
        check("R9 no repeat while pending", {31'b0, irq_out}, 32'h0);
        wr(A_STS, 32'h01);
        pulse(4'b0001);
        check("R9 new assertion", {31'b0, irq_out}, 32'h1);
        wr(A_STS, 32'h01);
    endtask

    task automatic t_fall();
        wr(A_EN, 32'h8000_0019);
        check("R10 idle", {31'b0, irq_out}, 32'h1);
        pulse(4'b0001);
        check("R10 low pulse", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R10 one cycle", {31'b0, irq_out}, 32'h1);
        wr(A_STS, 32'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_regs();
        t_gating();
        t_level_low();
        t_rise();
        t_fall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule